// File: doc/BRIEF.md
# Coincident-Edge Sync Pulse Generator

This block sits next to two clock divider banks, A and C, that both count down one fast source clock. Each bank's divide ratio comes from a two-bit select, and a shared pre-divide control can scale both ratios by a common factor. The block keeps its own phase counter in step with the two banks. From that counter it drives an active-low marker that warns downstream logic that the two banks are about to produce a rising edge at the same moment.

The marker is low for exactly one period of whichever bank runs faster. It returns high one such period before the shared edge. A single enable holds the marker low when cleared. A change of the enable takes effect only on a shared edge, so the marker never produces a shortened pulse. Whenever a select changes, the phase restarts, and the marker stays quiet until the restarted phase has completed one full span.

Top module: `coinc_sync_gen`

## Requirements
- R1: With `prediv_off`=1, bank A divides the source clock by 4, 6, 8 or 12 for `sel_a` = 0, 1, 2 or 3. Bank C divides by 2, 4, 6 or 8 for `sel_c` = 0, 1, 2 or 3. With `prediv_off`=0, both ratios are multiplied by PRE_DIV (default 2). The pulse start position follows these ratios.
- R2: Let Pf be the smaller of the two ratios and L their least common multiple. The phase repeats every M = max(L, 2·Pf) source cycles. Phase 0 is a common rising edge of both banks.
- R3: While aligned and enabled, `sync_n` is 0 exactly when the phase lies in [M−2·Pf, M−Pf). That is one faster-bank period.
- R4: `sync_n` rises at phase M−Pf, which is a rising edge of the faster bank exactly Pf cycles before the common edge.
- R5: When both ratios are equal, `sync_n` alternates: low for one period, then high for one period.
- R6: At a clock edge where {`prediv_off`,`sel_a`,`sel_c`} differs from the held setting, the phase restarts at 0. `sync_n` then stays 1 (if enabled) for the next M cycles, until the first wrap re-establishes alignment.
- R7: `sync_en`=0 freezes `sync_n` at 0. The enable is taken only on a wrap edge, on a setting change, or while not yet aligned.
- R8: During reset, `sync_n` is 0, the phase is 0 and the block is unaligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast source clock shared by both divider banks |
| rst_n | input | 1 | Active-low asynchronous reset |
| prediv_off | input | 1 | 1: ratios as listed; 0: ratios scaled by PRE_DIV |
| sel_a | input | 2 | Bank A ratio select |
| sel_c | input | 2 | Bank C ratio select |
| sync_en | input | 1 | 0 freezes the marker low |
| sync_n | output | 1 | Active-low coincidence marker |

## Verification
An enable change and a phase wrap can land on the same clock edge. So can an enable change and the first edge that re-establishes alignment after a setting change. The sweep drops the enable at chosen offsets for each setting: just before alignment, on the alignment edge, one cycle before a later wrap, and exactly on it. The sweep covers every select and pre-divide combination. The arithmetic expectation decides whether the freeze may already show on that edge or must wait for the next wrap. Every setting change in the sweep also arrives while the previous setting is aligned, which tests the restart against a running pulse.

// File: rtl/coinc_sync_pkg.sv
package coinc_sync_pkg;

   localparam int SEL_W = 2;
   localparam int CFG_W = 1 + 2 * SEL_W;
   localparam int NCFG  = 1 << CFG_W;

   typedef struct packed {
      logic             prediv_off;
      logic [SEL_W-1:0] sel_a;
      logic [SEL_W-1:0] sel_c;
   } ratio_cfg_t;

   function automatic int bank_a_div(int sel, int off, int pre);
      int base;
      base = (((sel % 2) != 0) ? 3 : 2) * (((sel / 2) != 0) ? 2 : 1) * 2;
      return (off != 0) ? base : base * pre;
   endfunction

   function automatic int bank_c_div(int sel, int off, int pre);
      int base;
      base = 2 * (sel + 1);
      return (off != 0) ? base : base * pre;
   endfunction

   function automatic int gcd_of(int a, int b);
      int x, y, t;
      x = a;
      y = b;
      while (y != 0) begin
         t = x % y;
         x = y;
         y = t;
      end
      return x;
   endfunction

   function automatic int fast_of(int code, int pre);
      int pa, pc;
      pa = bank_a_div((code >> SEL_W) % 4, (code >> (2 * SEL_W)) % 2, pre);
      pc = bank_c_div(code % 4, (code >> (2 * SEL_W)) % 2, pre);
      return (pa < pc) ? pa : pc;
   endfunction

   function automatic int span_of(int code, int pre);
      int pa, pc, l, f;
      pa = bank_a_div((code >> SEL_W) % 4, (code >> (2 * SEL_W)) % 2, pre);
      pc = bank_c_div(code % 4, (code >> (2 * SEL_W)) % 2, pre);
      l  = (pa / gcd_of(pa, pc)) * pc;
      f  = (pa < pc) ? pa : pc;
      return (l > 2 * f) ? l : 2 * f;
   endfunction

   function automatic int max_span(int pre);
      int m;
      m = 0;
      for (int g = 0; g < NCFG; g++)
         if (span_of(g, pre) > m) m = span_of(g, pre);
      return m;
   endfunction

endpackage

// File: rtl/coinc_sync_lut.sv
module coinc_sync_lut
   import coinc_sync_pkg::*;
#(
   parameter int PRE_DIV = 2,
   parameter int CNT_W   = 6
) (
   input  ratio_cfg_t       cfg,
   output logic [CNT_W-1:0] wrap_at,
   output logic [CNT_W-1:0] win_lo,
   output logic [CNT_W-1:0] win_hi
);

   logic [CNT_W-1:0] wrap_tab [NCFG];
   logic [CNT_W-1:0] lo_tab   [NCFG];
   logic [CNT_W-1:0] hi_tab   [NCFG];

   for (genvar g = 0; g < NCFG; g++) begin : g_cfg
      localparam int SPAN = span_of(g, PRE_DIV);
      localparam int FAST = fast_of(g, PRE_DIV);
      assign wrap_tab[g] = CNT_W'(SPAN - 1);
      assign lo_tab[g]   = CNT_W'(SPAN - 2 * FAST);
      assign hi_tab[g]   = CNT_W'(SPAN - FAST);
   end

   assign wrap_at = wrap_tab[cfg];
   assign win_lo  = lo_tab[cfg];
   assign win_hi  = hi_tab[cfg];

endmodule

// File: rtl/coinc_sync_phase.sv
module coinc_sync_phase
   import coinc_sync_pkg::*;
#(
   parameter int CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  ratio_cfg_t       cfg_in,
   input  logic             en_in,
   input  logic [CNT_W-1:0] wrap_at,
   output ratio_cfg_t       cfg_q,
   output logic [CNT_W-1:0] cnt,
   output logic             aligned,
   output logic             en_q,
   output logic             changed
);

   logic at_wrap;

   assign changed = (cfg_in != cfg_q);
   assign at_wrap = (cnt == wrap_at);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q   <= '0;
         cnt     <= '0;
         aligned <= 1'b0;
         en_q    <= 1'b0;
      end else if (changed) begin
         cfg_q   <= cfg_in;
         cnt     <= '0;
         aligned <= 1'b0;
         en_q    <= en_in;
      end else begin
         if (at_wrap) begin
            cnt     <= '0;
            aligned <= 1'b1;
         end else begin
            cnt <= cnt + 1'b1;
         end
         if (!aligned || at_wrap) en_q <= en_in;
      end
   end

   // R6
   realign_chk: assert property (@(posedge clk) disable iff (!rst_n)
      changed |=> (cnt == '0) && !aligned);

   // R2
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(changed) |-> cnt <= wrap_at);

endmodule

// File: rtl/coinc_sync_window.sv
module coinc_sync_window #(
   parameter int CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] win_lo,
   input  logic [CNT_W-1:0] win_hi,
   input  logic             aligned,
   input  logic             en_q,
   input  logic             changed,
   output logic             sync_n
);

   logic in_win;

   assign in_win = aligned && (cnt >= win_lo) && (cnt < win_hi);
   assign sync_n = en_q ? !in_win : 1'b0;

   // R4
   rise_place_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(sync_n) && en_q && $past(en_q) && aligned) |-> cnt == win_hi);

   // R3
   pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(sync_n) && en_q && !changed) |=> !sync_n);

   // R6
   quiet_unaligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!aligned && en_q) |-> sync_n);

endmodule

// File: rtl/coinc_sync_gen.sv
module coinc_sync_gen
   import coinc_sync_pkg::*;
#(
   parameter int PRE_DIV = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             prediv_off,
   input  logic [SEL_W-1:0] sel_a,
   input  logic [SEL_W-1:0] sel_c,
   input  logic             sync_en,
   output logic             sync_n
);

   localparam int MAX_SPAN = max_span(PRE_DIV);
   localparam int CNT_W    = $clog2(MAX_SPAN + 1);

   initial begin
      pre_div_param_chk: assert (PRE_DIV >= 1 && PRE_DIV <= 8)
         else $error("PRE_DIV out of range");
   end

   ratio_cfg_t       cfg_in, cfg_q;
   logic [CNT_W-1:0] cnt, wrap_at, win_lo, win_hi;
   logic             aligned, en_q, changed;

   assign cfg_in = '{prediv_off: prediv_off, sel_a: sel_a, sel_c: sel_c};

   coinc_sync_lut #(.PRE_DIV(PRE_DIV), .CNT_W(CNT_W)) u_lut (
      .cfg     (cfg_q),
      .wrap_at (wrap_at),
      .win_lo  (win_lo),
      .win_hi  (win_hi)
   );

   coinc_sync_phase #(.CNT_W(CNT_W)) u_phase (
      .clk     (clk),
      .rst_n   (rst_n),
      .cfg_in  (cfg_in),
      .en_in   (sync_en),
      .wrap_at (wrap_at),
      .cfg_q   (cfg_q),
      .cnt     (cnt),
      .aligned (aligned),
      .en_q    (en_q),
      .changed (changed)
   );

   coinc_sync_window #(.CNT_W(CNT_W)) u_win (
      .clk     (clk),
      .rst_n   (rst_n),
      .cnt     (cnt),
      .win_lo  (win_lo),
      .win_hi  (win_hi),
      .aligned (aligned),
      .en_q    (en_q),
      .changed (changed),
      .sync_n  (sync_n)
   );

   // R7
   freeze_on_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(!sync_en) && ($past(cnt) == $past(wrap_at))) |-> !sync_n);

   // R8
   always_comb begin
      if (!rst_n) begin
         reset_state_chk: assert (!sync_n);
      end
   end

endmodule

// File: tb/coinc_sync_gen_test.sv
module coinc_sync_gen_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       prediv_off = 1'b0;
   logic [1:0] sel_a = 2'd0;
   logic [1:0] sel_c = 2'd0;
   logic       sync_en = 1'b0;
   logic       sync_n;

   int vectors = 0;
   int miscompares = 0;
   bit done = 1'b0;

   localparam int PRE = 2;

   always #2 clk = ~clk;

   coinc_sync_gen #(.PRE_DIV(PRE)) uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .prediv_off (prediv_off),
      .sel_a      (sel_a),
      .sel_c      (sel_c),
      .sync_en    (sync_en),
      .sync_n     (sync_n)
   );

   function automatic int ratio_a(int s, int off);
      int t[4] = '{4, 6, 8, 12};
      return off ? t[s] : t[s] * PRE;
   endfunction

   function automatic int ratio_c(int s, int off);
      int t[4] = '{2, 4, 6, 8};
      return off ? t[s] : t[s] * PRE;
   endfunction

   function automatic int gcd2(int a, int b);
      return (b == 0) ? a : gcd2(b, a % b);
   endfunction

   task automatic check(string tag, logic got, logic exp, int cfg, int k);
      vectors++;
      if (got !== exp) begin
         miscompares++;
         $display("FAIL %s cfg=%0d cycle=%0d sync_n=%0b expected %0b",
                  tag, cfg, k, got, exp);
      end
   endtask

   task automatic run_cfg(int off, int sa, int sc);
      int pa, pc, pf, lcm, m, d, ph, cfg;
      bit drop, enq, en_drv, low;
      string tag;
      pa   = ratio_a(sa, off);
      pc   = ratio_c(sc, off);
      pf   = (pa < pc) ? pa : pc;
      lcm  = (pa / gcd2(pa, pc)) * pc;
      m    = (lcm > 2 * pf) ? lcm : 2 * pf;
      cfg  = off * 16 + sa * 4 + sc;
      drop = (sc % 2) == 1;
      case (sa)
         0: d = m - 2;
         1: d = m;
         2: d = 2 * m - 1;
         default: d = 2 * m;
      endcase
      enq = 1'b0;
      for (int k = 0; k < 3 * m; k++) begin
         en_drv = !(drop && k >= d);
         @(negedge clk);
         if (k == 0) begin
            prediv_off = off[0];
            sel_a      = sa[1:0];
            sel_c      = sc[1:0];
         end
         sync_en = en_drv;
         @(posedge clk);
         #1;
         if (k <= m || (k % m) == 0) enq = en_drv;
         ph  = k % m;
         low = !enq || (k >= m && ph >= m - 2 * pf && ph < m - pf);
         if (!enq)                 tag = "R7";
         else if (k < m)           tag = "R6";
         else if (ph == m - 2 * pf) tag = "R1";
         else if (ph == m - pf)     tag = "R4";
         else if (pa == pc)         tag = "R5";
         else if (low)              tag = "R3";
         else                       tag = "R2";
         check(tag, sync_n, !low, cfg, k);
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R8: marker frozen low in reset
      check("R8", sync_n, 1'b0, 0, 0);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      check("R8", sync_n, 1'b0, 0, 0);
      for (int off = 1; off >= 0; off--)
         for (int sa = 0; sa < 4; sa++)
            for (int sc = 0; sc < 4; sc++)
               run_cfg(off, sa, sc);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog expired after %0d vectors, expected completion", vectors);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

endmodule